// File: doc/BRIEF.md
# Amplifier Fault Protection Controller

This block watches the digital fault indications of a two-channel class-D power stage and decides when the fault flag is pulled low and when the bridge outputs go to high impedance. Its inputs are flags that analog comparators have already produced: over-current, over-temperature, a per-channel "DC offset beyond threshold" flag with its sign, and supply under-voltage and over-voltage. It also takes the active-low shutdown input.

Faults come in two classes. Over-current, over-temperature and persistent DC offset are held in a latch. They pull the fault flag low and keep the outputs off until shutdown is driven low. Supply faults only turn the outputs off, and they release on their own. A DC fault counts only after the offset has stayed beyond threshold with one polarity for more than a programmable number of cycles, with a separate timer for each channel. The fault flag can be wired back to the shutdown input. The controller then retries on its own: the latch clears, and it sets again on the next clock if the cause is still there. A small status code reports the first latched cause.

Top module: `ampfault_supervisor`

## Requirements
- R1: Over-current or over-temperature sampled with shutdown high drives `fault_n` low and `out_hiz` high from the next clock edge. Both remain so after the flag drops, for as long as shutdown stays high.
- R2: A channel whose `dc_over` bit is held high with a constant `dc_pos` bit (1 = positive) for DC_HOLD_CYCLES consecutive edges latches a DC fault on the following edge. `fault_n` is therefore still high after DC_HOLD_CYCLES edges and low after DC_HOLD_CYCLES+1 edges.
- R3: A channel's persistence count restarts when its `dc_pos` bit changes while `dc_over` is high, or when `dc_over` drops for a cycle. Each channel has its own count, and either channel can set the DC latch.
- R4: Under-voltage or over-voltage raises `out_hiz` one edge after it is sampled and releases it one edge after it clears. Neither one moves `fault_n`.
- R5: With `shdn_n` low, `out_hiz` is high in the same cycle. All latches clear at the next edge. Nothing latches and the DC counts stay at zero while `shdn_n` is low.
- R6: A latched cause that is still present when `shdn_n` returns high latches again at the first edge. With `fault_n` fed back to `shdn_n` and the cause held, `fault_n` alternates every cycle.
- R7: `first_cause` reads 0 (none), 1 (over-current), 2 (over-temperature) or 3 (DC). It records the first latched cause, with priority 1 > 2 > 3 on the same edge, and holds it until the latches clear.
- R8: During and right after reset, `fault_n` is high, `first_cause` is 0 and `out_hiz` follows only the shutdown input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown; a low pulse clears latched faults |
| oc_flag | input | 1 | Over-current flag |
| ot_flag | input | 1 | Over-temperature flag |
| dc_over | input | NUM_CH | Per-channel DC offset beyond threshold |
| dc_pos | input | NUM_CH | Per-channel DC offset sign, 1 = positive |
| uv_flag | input | 1 | Supply under-voltage flag |
| ov_flag | input | 1 | Supply over-voltage flag |
| fault_n | output | 1 | Active-low fault flag (open-drain level) |
| out_hiz | output | 1 | High to put the bridge outputs in high impedance |
| first_cause | output | 2 | Code of the first latched cause |

## Verification
Latched faults and supply faults appear one clock edge after the flag is sampled. A DC fault appears DC_HOLD_CYCLES+1 edges after a steady same-polarity offset begins or restarts. The mute from shutdown is combinational and shows up within the same cycle. The bench changes its inputs at the falling edge and reads the outputs at a later falling edge, after exactly the number of rising edges each result needs. For DC runs it checks just before and just after the expected edge, and it reads the shutdown mute a nanosecond after driving it.

// File: rtl/ampfault_pkg.sv
package ampfault_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_OC   = 2'd1,
      CAUSE_OT   = 2'd2,
      CAUSE_DC   = 2'd3
   } cause_e;

   localparam int unsigned LATCH_KINDS = 3;
endpackage

// File: rtl/dc_persist_timer.sv
module dc_persist_timer #(
   parameter int unsigned HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic over,
   input  logic pos,
   output logic trip
);
   localparam int unsigned CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] LIMIT = CW'(HOLD);

   logic [CW-1:0] cnt_q;
   logic          pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pos_q <= 1'b0;
      end else begin
         pos_q <= pos;
         if (!run_en || !over)
            cnt_q <= '0;
         else if (cnt_q != '0 && pos != pos_q)
            cnt_q <= CW'(1);
         else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + CW'(1);
      end
   end

   assign trip = (cnt_q == LIMIT);
endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank
   import ampfault_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   shdn_n,
   input  logic                   oc,
   input  logic                   ot,
   input  logic                   dc,
   output logic [LATCH_KINDS-1:0] latched,
   output cause_e                 first
);
   logic [LATCH_KINDS-1:0] set_vec;
   cause_e                 pick;

   assign set_vec = {dc, ot, oc};

   always_comb begin
      if (oc)      pick = CAUSE_OC;
      else if (ot) pick = CAUSE_OT;
      else if (dc) pick = CAUSE_DC;
      else         pick = CAUSE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= '0;
         first   <= CAUSE_NONE;
      end else if (!shdn_n) begin
         latched <= '0;
         first   <= CAUSE_NONE;
      end else begin
         latched <= latched | set_vec;
         if (latched == '0)
            first <= pick;
      end
   end
endmodule

// File: rtl/ampfault_supervisor.sv
module ampfault_supervisor
   import ampfault_pkg::*;
#(
   parameter int unsigned NUM_CH         = 2,
   parameter int unsigned DC_HOLD_CYCLES = 64000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shdn_n,
   input  logic              oc_flag,
   input  logic              ot_flag,
   input  logic [NUM_CH-1:0] dc_over,
   input  logic [NUM_CH-1:0] dc_pos,
   input  logic              uv_flag,
   input  logic              ov_flag,
   output logic              fault_n,
   output logic              out_hiz,
   output logic [1:0]        first_cause
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (DC_HOLD_CYCLES < 2) begin : g_bad_hold
      $error("DC_HOLD_CYCLES must be at least 2");
   end

   logic [NUM_CH-1:0]      ch_trip;
   logic [LATCH_KINDS-1:0] latched;
   cause_e                 first;
   logic                   supply_bad_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dc_persist_timer #(.HOLD(DC_HOLD_CYCLES)) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .run_en (shdn_n),
         .over   (dc_over[c]),
         .pos    (dc_pos[c]),
         .trip   (ch_trip[c])
      );
   end

   fault_latch_bank u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .shdn_n  (shdn_n),
      .oc      (oc_flag),
      .ot      (ot_flag),
      .dc      (|ch_trip),
      .latched (latched),
      .first   (first)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) supply_bad_q <= 1'b0;
      else        supply_bad_q <= uv_flag | ov_flag;
   end

   assign fault_n     = ~|latched;
   assign out_hiz     = (|latched) | supply_bad_q | ~shdn_n;
   assign first_cause = first;
endmodule

// File: rtl/ampfault_checker.sv
module ampfault_checker #(
   parameter int unsigned NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shdn_n,
   input logic              oc_flag,
   input logic              ot_flag,
   input logic              uv_flag,
   input logic              ov_flag,
   input logic [NUM_CH-1:0] dc_over,
   input logic              fault_n,
   input logic              out_hiz,
   input logic [1:0]        first_cause
);
   assert_oc_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_flag && shdn_n) |=> !fault_n);

   assert_ot_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ot_flag && shdn_n) |=> !fault_n);

   assert_latch_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n && shdn_n) |=> !fault_n);

   assert_fault_mutes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> out_hiz);

   assert_supply_mutes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_flag || ov_flag) |=> out_hiz);

   assert_shdn_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |=> fault_n);

   assert_cause_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_n |-> (first_cause == 2'd0));

   assert_cause_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n && shdn_n) |=> $stable(first_cause));
endmodule

bind ampfault_supervisor ampfault_checker #(.NUM_CH(NUM_CH)) u_ampfault_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .shdn_n      (shdn_n),
   .oc_flag     (oc_flag),
   .ot_flag     (ot_flag),
   .uv_flag     (uv_flag),
   .ov_flag     (ov_flag),
   .dc_over     (dc_over),
   .fault_n     (fault_n),
   .out_hiz     (out_hiz),
   .first_cause (first_cause)
);

// File: tb/ampfault_supervisor_test.sv
`timescale 1ns/1ps
module ampfault_supervisor_test;
   localparam int unsigned NCH  = 2;
   localparam int unsigned HOLD = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           shdn_drv = 1'b1;
   logic           loop_en = 1'b0;
   logic           shdn_n;
   logic           oc_flag = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
   logic [NCH-1:0] dc_over = '0, dc_pos = '0;
   logic           fault_n, out_hiz;
   logic [1:0]     first_cause;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   assign shdn_n = loop_en ? fault_n : shdn_drv;

   ampfault_supervisor #(.NUM_CH(NCH), .DC_HOLD_CYCLES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n),
      .oc_flag(oc_flag), .ot_flag(ot_flag),
      .dc_over(dc_over), .dc_pos(dc_pos),
      .uv_flag(uv_flag), .ov_flag(ov_flag),
      .fault_n(fault_n), .out_hiz(out_hiz), .first_cause(first_cause)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_latch();
      shdn_drv = 1'b0;
      step(1);
      shdn_drv = 1'b1;
      step(1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R8", "fault_n in reset", fault_n, 1);
      chk("R8", "first_cause in reset", first_cause, 0);
      chk("R8", "out_hiz in reset", out_hiz, 0);
      rst_n = 1'b1;
      step(1);
      chk("R8", "fault_n after reset", fault_n, 1);
      chk("R8", "out_hiz after reset", out_hiz, 0);
   endtask

   task automatic t_overcurrent();
      oc_flag = 1'b1;
      step(1);
      chk("R1", "oc fault_n", fault_n, 0);
      chk("R1", "oc out_hiz", out_hiz, 1);
      chk("R7", "oc cause", first_cause, 1);
      oc_flag = 1'b0;
      step(3);
      chk("R1", "oc held fault_n", fault_n, 0);
      shdn_drv = 1'b0;
      #1;
      chk("R5", "shdn mute same cycle", out_hiz, 1);
      step(1);
      chk("R5", "shdn clears fault_n", fault_n, 1);
      chk("R5", "shdn clears cause", first_cause, 0);
      shdn_drv = 1'b1;
      step(1);
      chk("R5", "out_hiz released", out_hiz, 0);
   endtask

   task automatic t_overtemp_relatch();
      ot_flag = 1'b1;
      step(1);
      chk("R1", "ot fault_n", fault_n, 0);
      chk("R7", "ot cause", first_cause, 2);
      shdn_drv = 1'b0;
      step(1);
      chk("R5", "ot cleared while low", fault_n, 1);
      shdn_drv = 1'b1;
      step(1);
      chk("R6", "ot relatched", fault_n, 0);
      ot_flag = 1'b0;
      clear_latch();
      chk("R6", "ot gone after cycle", fault_n, 1);
      chk("R6", "outputs on after cycle", out_hiz, 0);
   endtask

   task automatic t_priority();
      oc_flag = 1'b1; ot_flag = 1'b1;
      step(1);
      chk("R7", "same-edge priority", first_cause, 1);
      oc_flag = 1'b0; ot_flag = 1'b0;
      clear_latch();
      ot_flag = 1'b1;
      step(1);
      oc_flag = 1'b1;
      step(1);
      chk("R7", "first kept over later oc", first_cause, 2);
      oc_flag = 1'b0; ot_flag = 1'b0;
      clear_latch();
   endtask

   task automatic t_dc_basic();
      dc_over = 2'b01; dc_pos = 2'b01;
      step(HOLD);
      chk("R2", "dc not yet", fault_n, 1);
      step(1);
      chk("R2", "dc latched", fault_n, 0);
      chk("R7", "dc cause", first_cause, 3);
      dc_over = '0;
      clear_latch();
   endtask

   task automatic t_dc_flip();
      dc_over = 2'b10; dc_pos = 2'b10;
      step(HOLD - 1);
      dc_pos = 2'b00;
      step(HOLD);
      chk("R3", "flip restarted ch1", fault_n, 1);
      step(1);
      chk("R3", "ch1 latched after restart", fault_n, 0);
      dc_over = '0;
      clear_latch();
   endtask

   task automatic t_dc_dropout();
      dc_over = 2'b01; dc_pos = 2'b00;
      step(HOLD - 1);
      dc_over = 2'b00;
      step(1);
      dc_over = 2'b01;
      step(HOLD);
      chk("R3", "dropout restarted ch0", fault_n, 1);
      step(1);
      chk("R3", "ch0 latched after dropout", fault_n, 0);
      dc_over = '0;
      clear_latch();
   endtask

   task automatic t_supply();
      uv_flag = 1'b1;
      step(1);
      chk("R4", "uv mutes", out_hiz, 1);
      chk("R4", "uv no flag", fault_n, 1);
      uv_flag = 1'b0;
      step(1);
      chk("R4", "uv releases", out_hiz, 0);
      ov_flag = 1'b1;
      step(1);
      chk("R4", "ov mutes", out_hiz, 1);
      chk("R4", "ov no flag", fault_n, 1);
      ov_flag = 1'b0;
      step(1);
      chk("R4", "ov releases", out_hiz, 0);
   endtask

   task automatic t_shdn_blocks();
      shdn_drv = 1'b0;
      oc_flag = 1'b1; dc_over = 2'b01; dc_pos = 2'b01;
      step(HOLD + 3);
      chk("R5", "no latch while low", fault_n, 1);
      chk("R5", "muted while low", out_hiz, 1);
      oc_flag = 1'b0;
      shdn_drv = 1'b1;
      step(HOLD);
      chk("R5", "dc count held at zero", fault_n, 1);
      step(1);
      chk("R5", "dc counts after release", fault_n, 0);
      dc_over = '0;
      clear_latch();
   endtask

   task automatic t_auto_retry();
      oc_flag = 1'b1;
      loop_en = 1'b1;
      step(1);
      chk("R6", "retry latch", fault_n, 0);
      step(1);
      chk("R6", "retry clear", fault_n, 1);
      step(1);
      chk("R6", "retry relatch", fault_n, 0);
      oc_flag = 1'b0;
      step(2);
      chk("R6", "retry settles", fault_n, 1);
      loop_en = 1'b0;
      shdn_drv = 1'b1;
      step(1);
      chk("R6", "retry outputs on", out_hiz, 0);
   endtask

   initial begin
      #(4 * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_overcurrent();
      t_overtemp_relatch();
      t_priority();
      t_dc_basic();
      t_dc_flip();
      t_dc_dropout();
      t_supply();
      t_shdn_blocks();
      t_auto_retry();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule